// File: doc/BRIEF.md
# Mixed-Radix Digit-Serial Programme Subtractor

This block forms a divider programme from two numbers that arrive one digit at a time. On each load strobe it takes one digit of a minuend and one digit of a subtrahend, lowest digit first. It subtracts them together with the borrow carried from the previous digit, and stores the result in that digit's slot. The lowest digit counts in a programmable radix M, from 1 to 16. The five digits above it are decimal. A full number therefore has the value `((d5*10^4 + d4*10^3 + d3*10^2 + d2*10 + d1)*M) + d0`.

Both digit inputs use active-low coding, so each nibble is inverted before any arithmetic. A borrow-in is applied to the lowest digit only. Subtraction results below zero wrap by M·10^5, because the borrow chain wraps that way by nature. The borrow left after the top digit is brought out so that a unit of higher significance can use it as its own borrow-in.

The block also reports the highest non-zero digit among result digits 2 to 5, or a flag when all four are zero. Downstream counters and rate selectors read the six stored digits directly.

Top module: `prog_digit_subtractor`

## Requirements
- R1: After reset all six stored result digits are 0, `borrowOut` is 0, `leadDigit` is 0 and `leadNone` is 1.
- R2: Both digit inputs are active-low. The digit used in the arithmetic is the bitwise inverse of the input nibble, so 4'hF means 0 and 4'h0 means 15.
- R3: A load with `digitIdx` = 0 computes a − b − `borrowIn` in radix M. If the result is below zero, M is added and the borrow is set. M is read from `radixCode`, where 1 to 15 mean themselves and 0 means 16.
- R4: A load with `digitIdx` from 1 to 5 computes a − b − (the borrow left by the previous load) in radix 10, with the same add-and-borrow rule.
- R5: `borrowIn` is used only on a load of digit 0. At any other load its value has no effect.
- R6: When six loads of digits 0 to 5 are made in order, the stored digits equal A − B − borrowIn. When that value is negative, they equal A − B − borrowIn + M·10^5. The number values follow the mixed-radix formula above.
- R7: `borrowOut` is the borrow left by the most recent load. After digit 5 is loaded it is the final borrow, and it holds until the next load.
- R8: `leadDigit` is the highest-numbered non-zero digit among stored digits 5, 4, 3 and 2, and `leadNone` is 0. If all four are zero, `leadDigit` is 0 and `leadNone` is 1. Digits 0 and 1 are never considered.
- R9: With `digitValid` low, or with `digitIdx` of 6 or 7, no stored digit and no borrow changes.
- R10: A load writes only the slot selected by `digitIdx` (4 bits per slot, slot k at bits 4k+3 to 4k of `resultDigits`). All other slots keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| digitValid | input | 1 | Load strobe for the current digit |
| digitIdx | input | 3 | Index of the digit being loaded, 0 to 5 |
| aNibN | input | 4 | Minuend digit, active-low coding |
| bNibN | input | 4 | Subtrahend digit, active-low coding |
| borrowIn | input | 1 | Borrow-in, used on digit 0 only |
| radixCode | input | 4 | Lowest-digit radix M; 0 means 16 |
| resultDigits | output | 24 | Six stored result digits, digit k at bits 4k+3:4k |
| leadDigit | output | 4 | Highest non-zero digit among digits 5 to 2 |
| leadNone | output | 1 | Set when digits 5 to 2 are all zero |
| borrowOut | output | 1 | Borrow left by the latest load |

## Verification
A load is captured by the rising edge at which `digitValid` is high. The stored digit and `borrowOut` therefore change one edge after the stimulus. `leadDigit` and `leadNone` are decoded without a register from the stored digits, so they move in the same cycle as the digits. The bench drives inputs on the falling edge and samples every result on the next falling edge after the capturing rising edge. That is half a cycle after the only register stage and well before the following edge. The expected digits come from whole-number arithmetic on the full A and B values, not from digit-by-digit subtraction.

// File: rtl/progsub_pkg.sv
package progsub_pkg;
  localparam int NUM_DIGITS = 6;
  localparam int DIGIT_W    = 4;
  localparam int IDX_W      = $clog2(NUM_DIGITS);

  typedef struct packed {
    logic                  loadEn;
    logic                  firstDigit;
    logic [NUM_DIGITS-1:0] slotSel;
  } strobe_t;
endpackage

// File: rtl/ps_ctrl.sv
module ps_ctrl
  import progsub_pkg::*;
#(
  parameter int DIGITS = NUM_DIGITS,
  parameter int IW     = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          digitValid,
  input  logic [IW-1:0] digitIdx,
  output strobe_t       strobes
);
  always_comb begin
    strobes = '0;
    for (int k = 0; k < DIGITS; k++) begin
      if (digitValid && (digitIdx == IW'(k))) begin
        strobes.slotSel[k] = 1'b1;
      end
    end
    strobes.loadEn     = |strobes.slotSel;
    strobes.firstDigit = strobes.slotSel[0];
  end

  // R10: at most one slot is targeted by any load
  a_r10_one_slot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.slotSel));

  // R9: an index beyond the last digit never produces a load
  a_r9_bad_index: assert property (@(posedge clk) disable iff (!rstN)
    (digitIdx >= IW'(DIGITS)) |-> !strobes.loadEn);
endmodule

// File: rtl/ps_digit_sub.sv
module ps_digit_sub #(
  parameter int W = 4
) (
  input  logic [W-1:0] aVal,
  input  logic [W-1:0] bVal,
  input  logic         brIn,
  input  logic [W:0]   radix,
  output logic [W-1:0] diff,
  output logic         brOut
);
  logic [W+1:0] raw;
  logic [W+1:0] fixed;

  always_comb begin
    raw   = {2'b00, aVal} - {2'b00, bVal} - {{(W+1){1'b0}}, brIn};
    brOut = raw[W+1];
    fixed = brOut ? (raw + {1'b0, radix}) : raw;
    diff  = fixed[W-1:0];
  end
endmodule

// File: rtl/ps_lead_detect.sv
module ps_lead_detect #(
  parameter int DIGITS = 6,
  parameter int W      = 4,
  parameter int LO     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIGITS*W-1:0] digitsFlat,
  output logic [W-1:0]      leadDigit,
  output logic              leadNone
);
  localparam int SPAN = DIGITS - LO;

  logic [SPAN-1:0] nzVec;

  genvar g;
  generate
    for (g = 0; g < SPAN; g++) begin : g_nz
      assign nzVec[g] = |digitsFlat[(g+LO)*W +: W];
    end
  endgenerate

  always_comb begin
    leadDigit = '0;
    for (int k = 0; k < SPAN; k++) begin
      if (nzVec[k]) leadDigit = digitsFlat[(k+LO)*W +: W];
    end
    leadNone = ~|nzVec;
  end

  // R8: the flag means the upper digits are all zero
  a_r8_none_means_zero: assert property (@(posedge clk) disable iff (!rstN)
    leadNone |-> (digitsFlat[DIGITS*W-1:LO*W] == '0));

  // R8: a reported digit is never zero
  a_r8_digit_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    !leadNone |-> (leadDigit != '0));

  // R8: the top slot wins whenever it is non-zero
  a_r8_top_priority: assert property (@(posedge clk) disable iff (!rstN)
    (digitsFlat[DIGITS*W-1 -: W] != '0) |-> (leadDigit == digitsFlat[DIGITS*W-1 -: W]));
endmodule

// File: rtl/ps_datapath.sv
module ps_datapath
  import progsub_pkg::*;
#(
  parameter int DIGITS    = NUM_DIGITS,
  parameter int W         = DIGIT_W,
  parameter int DEC_RADIX = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [W-1:0]      aNibN,
  input  logic [W-1:0]      bNibN,
  input  logic              borrowIn,
  input  logic [W-1:0]      radixCode,
  output logic [DIGITS*W-1:0] digitsFlat,
  output logic              borrowQ
);
  logic [W-1:0] aVal;
  logic [W-1:0] bVal;
  logic [W:0]   radixM;
  logic [W:0]   radixSel;
  logic         brSel;
  logic [W-1:0] diff;
  logic         brNext;
  logic [W-1:0] digitQ [DIGITS];

  assign aVal     = ~aNibN;
  assign bVal     = ~bNibN;
  assign radixM   = (radixCode == '0) ? (W+1)'(1 << W) : {1'b0, radixCode};
  assign radixSel = strobes.firstDigit ? radixM : (W+1)'(DEC_RADIX);
  assign brSel    = strobes.firstDigit ? borrowIn : borrowQ;

  ps_digit_sub #(.W(W)) sub_i (
    .aVal  (aVal),
    .bVal  (bVal),
    .brIn  (brSel),
    .radix (radixSel),
    .diff  (diff),
    .brOut (brNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      borrowQ <= 1'b0;
    end else if (strobes.loadEn) begin
      borrowQ <= brNext;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DIGITS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          digitQ[g] <= '0;
        end else if (strobes.slotSel[g]) begin
          digitQ[g] <= diff;
        end
      end
      assign digitsFlat[g*W +: W] = digitQ[g];
    end
  endgenerate

  // R9: without a load the stored digits do not move
  a_r9_hold_digits: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> $stable(digitsFlat));

  // R7: without a load the borrow does not move
  a_r7_hold_borrow: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> $stable(borrowQ));

  // R3: an in-range lowest digit stays below M after its load
  a_r3_digit0_range: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.firstDigit && ({1'b0, aVal} < radixM) && ({1'b0, bVal} < radixM))
      |=> ({1'b0, digitQ[0]} < $past(radixM)));

  // R4: a decimal slot loaded from decimal digits stays below ten
  a_r4_decimal_range: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.slotSel[1] && (aVal < W'(DEC_RADIX)) && (bVal < W'(DEC_RADIX)))
      |=> (digitQ[1] < W'(DEC_RADIX)));
endmodule

// File: rtl/prog_digit_subtractor.sv
module prog_digit_subtractor
  import progsub_pkg::*;
#(
  parameter int DIGITS    = NUM_DIGITS,
  parameter int W         = DIGIT_W,
  parameter int LEAD_LO   = 2,
  parameter int DEC_RADIX = 10,
  parameter int IW        = IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                digitValid,
  input  logic [IW-1:0]       digitIdx,
  input  logic [W-1:0]        aNibN,
  input  logic [W-1:0]        bNibN,
  input  logic                borrowIn,
  input  logic [W-1:0]        radixCode,
  output logic [DIGITS*W-1:0] resultDigits,
  output logic [W-1:0]        leadDigit,
  output logic                leadNone,
  output logic                borrowOut
);
  strobe_t strobes;

  ps_ctrl #(.DIGITS(DIGITS), .IW(IW)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .digitValid (digitValid),
    .digitIdx   (digitIdx),
    .strobes    (strobes)
  );

  ps_datapath #(.DIGITS(DIGITS), .W(W), .DEC_RADIX(DEC_RADIX)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .aNibN      (aNibN),
    .bNibN      (bNibN),
    .borrowIn   (borrowIn),
    .radixCode  (radixCode),
    .digitsFlat (resultDigits),
    .borrowQ    (borrowOut)
  );

  ps_lead_detect #(.DIGITS(DIGITS), .W(W), .LO(LEAD_LO)) lead_i (
    .clk        (clk),
    .rstN       (rstN),
    .digitsFlat (resultDigits),
    .leadDigit  (leadDigit),
    .leadNone   (leadNone)
  );
endmodule

// File: tb/prog_digit_subtractor_tb.sv
module prog_digit_subtractor_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        digitValid = 1'b0;
  logic [2:0]  digitIdx = '0;
  logic [3:0]  aNibN = 4'hF;
  logic [3:0]  bNibN = 4'hF;
  logic        borrowIn = 1'b0;
  logic [3:0]  radixCode = 4'd10;
  logic [23:0] resultDigits;
  logic [3:0]  leadDigit;
  logic        leadNone;
  logic        borrowOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  prog_digit_subtractor dut_i (
    .clk(clk), .rstN(rstN), .digitValid(digitValid), .digitIdx(digitIdx),
    .aNibN(aNibN), .bNibN(bNibN), .borrowIn(borrowIn), .radixCode(radixCode),
    .resultDigits(resultDigits), .leadDigit(leadDigit), .leadNone(leadNone),
    .borrowOut(borrowOut)
  );

  localparam int NV = 8;
  localparam logic [23:0] VA [NV] = '{24'h012345, 24'h000000, 24'h99999E, 24'h000000,
                                      24'h000005, 24'h300004, 24'h000500, 24'h000090};
  localparam logic [23:0] VB [NV] = '{24'h001122, 24'h000001, 24'h000000, 24'h000000,
                                      24'h000003, 24'h100006, 24'h000000, 24'h000000};
  localparam logic VBIN [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam int   VM   [NV] = '{10, 10, 16, 1, 7, 12, 3, 10};

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int numValue(input logic [23:0] x, input int m);
    int v = 0;
    for (int k = 5; k >= 1; k--) v = v * 10 + int'(x[k*4 +: 4]);
    return v * m + int'(x[3:0]);
  endfunction

  task automatic expectResult(input logic [23:0] a, input logic [23:0] b, input logic bin,
                              input int m, output logic [23:0] dig, output logic bor,
                              output int lead, output logic none);
    int p;
    int rest;
    p = numValue(a, m) - numValue(b, m) - int'(bin);
    bor = (p < 0);
    if (p < 0) p = p + m * 100000;
    dig = '0;
    dig[3:0] = 4'(p % m);
    rest = p / m;
    for (int k = 1; k <= 5; k++) begin
      dig[k*4 +: 4] = 4'(rest % 10);
      rest = rest / 10;
    end
    lead = 0;
    none = 1'b1;
    for (int k = 2; k <= 5; k++) begin
      if (dig[k*4 +: 4] != 4'd0) begin
        lead = int'(dig[k*4 +: 4]);
        none = 1'b0;
      end
    end
  endtask

  task automatic loadNumber(input logic [23:0] a, input logic [23:0] b, input logic bin, input int m);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      digitValid = 1'b1;
      digitIdx   = 3'(k);
      aNibN      = ~a[k*4 +: 4];
      bNibN      = ~b[k*4 +: 4];
      borrowIn   = (k == 0) ? bin : ~bin;  // R5: inverted on later digits
      radixCode  = (m == 16) ? 4'd0 : 4'(m);
    end
    @(negedge clk);
    digitValid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [23:0] expDig;
    logic        expBor;
    int          expLead;
    logic        expNone;
    logic [23:0] snap;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset digits", int'(resultDigits), 0);
    check("R1 reset borrow", int'(borrowOut), 0);
    check("R1 reset lead", int'(leadDigit), 0);
    check("R1 reset none", int'(leadNone), 1);

    // R6 R3 R4 R2 R5 R7 R8: vector table
    for (int v = 0; v < NV; v++) begin
      loadNumber(VA[v], VB[v], VBIN[v], VM[v]);
      expectResult(VA[v], VB[v], VBIN[v], VM[v], expDig, expBor, expLead, expNone);
      check($sformatf("R6 digits vec%0d", v), int'(resultDigits), int'(expDig));
      check($sformatf("R7 borrow vec%0d", v), int'(borrowOut), int'(expBor));
      check($sformatf("R8 lead vec%0d", v), expLead, expLead == 0 ? 0 : int'(leadDigit));
      check($sformatf("R8 lead value vec%0d", v), int'(leadDigit), expLead);
      check($sformatf("R8 none vec%0d", v), int'(leadNone), int'(expNone));
    end

    // R9: idle cycles and out-of-range indices change nothing
    snap = resultDigits;
    @(negedge clk);
    digitValid = 1'b0; digitIdx = 3'd2; aNibN = 4'h0; bNibN = 4'hF; borrowIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 idle digits", int'(resultDigits), int'(snap));
    digitValid = 1'b1; digitIdx = 3'd6;
    @(negedge clk);
    digitIdx = 3'd7;
    @(negedge clk);
    digitValid = 1'b0;
    @(negedge clk);
    check("R9 bad index digits", int'(resultDigits), int'(snap));
    check("R9 bad index borrow", int'(borrowOut), 0);

    // R10 R8: single load of slot 3 (7 - 2 - borrow 0 = 5)
    digitValid = 1'b1; digitIdx = 3'd3; aNibN = ~4'd7; bNibN = ~4'd2; borrowIn = 1'b1;
    @(negedge clk);
    digitValid = 1'b0;
    check("R10 only slot 3", int'(resultDigits), int'({snap[23:16], 4'd5, snap[11:0]}));
    check("R8 lead after slot 3", int'(leadDigit), 5);
    check("R8 none after slot 3", int'(leadNone), 0);
    check("R5 borrow ignored on slot 3", int'(borrowOut), 0);

    // R4 R7: slot 4 with 0 - 1 borrows in radix 10
    digitValid = 1'b1; digitIdx = 3'd4; aNibN = ~4'd0; bNibN = ~4'd1; borrowIn = 1'b0;
    @(negedge clk);
    digitValid = 1'b0;
    check("R4 wrap digit", int'(resultDigits[19:16]), 9);
    check("R7 borrow set", int'(borrowOut), 1);
    check("R8 lead from slot 4", int'(leadDigit), 9);

    // R3: digit 0 with M=16 (code 0), 2 - 5 - 1 -> 12, borrow
    digitValid = 1'b1; digitIdx = 3'd0; aNibN = ~4'd2; bNibN = ~4'd5; borrowIn = 1'b1;
    radixCode = 4'd0;
    @(negedge clk);
    digitValid = 1'b0;
    check("R3 radix16 digit", int'(resultDigits[3:0]), 12);
    check("R3 radix16 borrow", int'(borrowOut), 1);

    finish_run();
  end
endmodule